// File: doc/BRIEF.md
# Bus Access Firewall Monitor

This block sits beside a shared memory bus and judges every transfer against three guarded address windows: a code window, a constant-data window and a scratch-data window. Each transfer comes from either the CPU or a DMA master and is a fetch, a read or a write. The block keeps a three-state protection machine. In the dormant state nothing is checked. In the locked state the guarded windows are sealed. In the unlocked state trusted code is running and may touch its own data.

The only way into the unlocked state is a two-fetch entry handshake at a fixed offset inside an executable window. The block drops back to the locked state when the CPU fetches from outside the executable windows, but only if the exit permit input is high. Without the permit, and for any access that breaks the rules of the current state, the block emits a one-cycle reset request and falls back to the dormant state. It is then re-armed by the enable input.

Top module: `seg_guard`

## Requirements
- R1: After rst_ni the state output is IDLE (2'b00) and rst_req_o is 0. While the state is IDLE, no transfer of any kind or master raises rst_req_o.
- R2: From IDLE the state becomes CLOSE (2'b01) on the edge that sees enable_i high. Once the state is CLOSE or OPEN (2'b10), enable_i going low has no effect on the state.
- R3: A window is hit when base <= addr < base + length, using an unsigned compare without wrap. A window whose length is zero never hits.
- R4: kind_i encodes 00 = fetch, 01 = read, 10 = write, 11 = read. In CLOSE, any CPU transfer that hits the code window, the constant window, or a scratch window not marked shared raises a reset request. The only exceptions are the entry fetches of R5 and R6.
- R5: In CLOSE, a CPU fetch at code base + 4 arms the entry. If the next valid CPU transfer is a fetch at code base + 8, the state becomes OPEN. Any other next CPU transfer raises a reset request. Idle cycles and DMA transfers in between do not break the pairing.
- R6: The same entry is accepted at scratch base + 4 / + 8 only when the scratch window is executable (vd_exec_i = 1) and not shared (vd_shared_i = 0).
- R7: In OPEN, the code window allows fetch and read, and a write to it raises a reset request. The constant window allows read and write, and a fetch from it raises a reset request.
- R8: A shared scratch window allows every CPU transfer in CLOSE and OPEN. A non-shared scratch window allows read and write in OPEN, and allows fetch there only when it is executable.
- R9: In OPEN, a CPU fetch outside the code window, and outside the scratch window when that window is executable, leaves OPEN. If prearm_i is 1 the state becomes CLOSE without a reset request. If prearm_i is 0 a reset request is raised.
- R10: dma_i = 1 marks a DMA transfer. In CLOSE or OPEN, a DMA transfer that hits the code window, the constant window or a non-shared scratch window raises a reset request. A DMA transfer elsewhere leaves the state unchanged.
- R11: The reset request is a one-cycle registered pulse that appears on the edge that samples the offending transfer. On that same edge the state becomes IDLE. With enable_i held high, the state returns to CLOSE on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Arms monitoring from IDLE |
| vld_i | input | 1 | A transfer is present this cycle |
| dma_i | input | 1 | Transfer comes from the DMA master |
| kind_i | input | 2 | Transfer kind (fetch/read/write) |
| addr_i | input | AW | Byte address of the transfer |
| code_base_i | input | AW | Code window start |
| code_len_i | input | AW | Code window length in bytes |
| nvd_base_i | input | AW | Constant window start |
| nvd_len_i | input | AW | Constant window length in bytes |
| vd_base_i | input | AW | Scratch window start |
| vd_len_i | input | AW | Scratch window length in bytes |
| vd_shared_i | input | 1 | Scratch window is shared |
| vd_exec_i | input | 1 | Scratch window is executable |
| prearm_i | input | 1 | Exit permit for leaving OPEN |
| state_o | output | 2 | Current protection state |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The assertions assume that the three windows do not overlap and that no window wraps past the top of the address space. They also assume that window bounds and scratch attributes stay constant while an entry handshake is armed. The stimulus sets the windows at fixed, disjoint locations and changes the scratch attributes only while the machine is in CLOSE with no entry pending. Random phases pick addresses at the window edges and at the entry offsets, so every state is reached repeatedly, and the behavioural model is compared against the design on every clock.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;
  localparam int SEG_N      = 3;
  localparam int SEG_W      = 2;
  localparam int SEG_CODE   = 0;
  localparam int SEG_NVD    = 1;
  localparam int SEG_VD     = 2;
  localparam int ENTRY_OFS  = 4;
  localparam int SECOND_OFS = 8;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_WRITE = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLOSE = 2'd1,
    ST_OPEN  = 2'd2
  } gstate_e;
endpackage

// File: rtl/seg_guard_hit.sv
module seg_guard_hit import seg_guard_pkg::*; #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] len_i,
  output logic          hit_o,
  output logic          at_entry_o,
  output logic          at_second_o
);
  localparam int EW = AW + 1;

  logic          live;
  logic [EW-1:0] end_x;

  assign live  = |len_i;
  // widened end avoids wrap on windows near the top of memory
  assign end_x = {1'b0, base_i} + {1'b0, len_i};
  assign hit_o = live && (addr_i >= base_i) && ({1'b0, addr_i} < end_x);

  assign at_entry_o  = live && (addr_i == base_i + AW'(ENTRY_OFS));
  assign at_second_o = live && (addr_i == base_i + AW'(SECOND_OFS));
endmodule

// File: rtl/seg_guard_rules.sv
module seg_guard_rules import seg_guard_pkg::*; (
  input  gstate_e          state_i,
  input  logic             vld_i,
  input  logic             dma_i,
  input  logic [1:0]       kind_i,
  input  logic [SEG_N-1:0] hit_i,
  input  logic [SEG_N-1:0] at_entry_i,
  input  logic [SEG_N-1:0] at_second_i,
  input  logic             vd_shared_i,
  input  logic             vd_exec_i,
  input  logic             prearm_i,
  input  logic             armed_i,
  input  logic [SEG_W-1:0] arm_seg_i,
  output logic             viol_o,
  output logic             arm_o,
  output logic [SEG_W-1:0] arm_seg_o,
  output logic             open_o,
  output logic             close_o
);
  logic             is_fetch, is_write;
  logic             guarded, exec_hit, open_bad, leave, second_ok;
  logic [SEG_N-1:0] gate_ok, entry_hit;

  assign is_fetch = (kind_i == KIND_FETCH);
  assign is_write = (kind_i == KIND_WRITE);

  assign guarded  = hit_i[SEG_CODE] | hit_i[SEG_NVD] | (hit_i[SEG_VD] & ~vd_shared_i);
  assign exec_hit = hit_i[SEG_CODE] | (hit_i[SEG_VD] & vd_exec_i);

  // which windows may carry the entry handshake
  always_comb begin
    gate_ok           = '0;
    gate_ok[SEG_CODE] = 1'b1;
    gate_ok[SEG_VD]   = vd_exec_i & ~vd_shared_i;
  end
  assign entry_hit = at_entry_i & gate_ok;
  assign arm_seg_o = entry_hit[SEG_CODE] ? SEG_W'(SEG_CODE) : SEG_W'(SEG_VD);
  assign second_ok = is_fetch & at_second_i[arm_seg_i];

  assign open_bad = (hit_i[SEG_CODE] & is_write)
                  | (hit_i[SEG_NVD] & is_fetch)
                  | (hit_i[SEG_VD] & ~vd_shared_i & ~vd_exec_i & is_fetch);
  assign leave    = is_fetch & ~exec_hit;

  always_comb begin
    viol_o  = 1'b0;
    arm_o   = 1'b0;
    open_o  = 1'b0;
    close_o = 1'b0;
    if (vld_i && state_i != ST_IDLE) begin
      if (dma_i) begin
        viol_o = guarded;
      end else if (state_i == ST_CLOSE) begin
        if (armed_i) begin
          open_o = second_ok;
          viol_o = ~second_ok;
        end else if (is_fetch && |entry_hit) begin
          arm_o = 1'b1;
        end else begin
          viol_o = guarded;
        end
      end else begin
        viol_o  = open_bad | (leave & ~prearm_i);
        close_o = leave & prearm_i & ~open_bad;
      end
    end
  end
endmodule

// File: rtl/seg_guard_fsm.sv
module seg_guard_fsm import seg_guard_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             viol_i,
  input  logic             arm_i,
  input  logic [SEG_W-1:0] arm_seg_i,
  input  logic             open_i,
  input  logic             close_i,
  output gstate_e          state_o,
  output logic             armed_o,
  output logic [SEG_W-1:0] arm_seg_o,
  output logic             rst_req_o
);
  gstate_e          state_q, state_d;
  logic             armed_q, armed_d, req_q, req_d;
  logic [SEG_W-1:0] seg_q, seg_d;

  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    seg_d   = seg_q;
    req_d   = 1'b0;
    if (viol_i) begin
      state_d = ST_IDLE;
      armed_d = 1'b0;
      req_d   = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (enable_i) state_d = ST_CLOSE;
        ST_CLOSE: begin
          if (open_i) begin
            state_d = ST_OPEN;
            armed_d = 1'b0;
          end else if (arm_i) begin
            armed_d = 1'b1;
            seg_d   = arm_seg_i;
          end
        end
        ST_OPEN:  if (close_i) state_d = ST_CLOSE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b0;
      seg_q   <= '0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      seg_q   <= seg_d;
      req_q   <= req_d;
    end
  end

  assign state_o   = state_q;
  assign armed_o   = armed_q;
  assign arm_seg_o = seg_q;
  assign rst_req_o = req_q;

  AST_STATE_ENC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != 2'b11); // R1
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q); // R11
  AST_REQ_WITH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> state_q == ST_IDLE); // R11
  AST_OPEN_VIA_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_OPEN) |-> $past(state_q) == ST_CLOSE); // R5
  AST_ARMED_ONLY_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> state_q == ST_CLOSE); // R5
endmodule

// File: rtl/seg_guard.sv
module seg_guard import seg_guard_pkg::*; #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          vld_i,
  input  logic          dma_i,
  input  logic [1:0]    kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] code_base_i,
  input  logic [AW-1:0] code_len_i,
  input  logic [AW-1:0] nvd_base_i,
  input  logic [AW-1:0] nvd_len_i,
  input  logic [AW-1:0] vd_base_i,
  input  logic [AW-1:0] vd_len_i,
  input  logic          vd_shared_i,
  input  logic          vd_exec_i,
  input  logic          prearm_i,
  output logic [1:0]    state_o,
  output logic          rst_req_o
);
  logic [AW-1:0]    base_a [SEG_N];
  logic [AW-1:0]    len_a  [SEG_N];
  logic [SEG_N-1:0] hit, at_entry, at_second;
  logic             viol, arm, open_go, close_go, armed;
  logic [SEG_W-1:0] arm_seg_new, arm_seg_q;
  gstate_e          state;

  assign base_a[SEG_CODE] = code_base_i;
  assign len_a[SEG_CODE]  = code_len_i;
  assign base_a[SEG_NVD]  = nvd_base_i;
  assign len_a[SEG_NVD]   = nvd_len_i;
  assign base_a[SEG_VD]   = vd_base_i;
  assign len_a[SEG_VD]    = vd_len_i;

  for (genvar g = 0; g < SEG_N; g++) begin : g_win
    seg_guard_hit #(.AW(AW)) u_hit (
      .addr_i      (addr_i),
      .base_i      (base_a[g]),
      .len_i       (len_a[g]),
      .hit_o       (hit[g]),
      .at_entry_o  (at_entry[g]),
      .at_second_o (at_second[g])
    );
  end

  seg_guard_rules u_rules (
    .state_i     (state),
    .vld_i       (vld_i),
    .dma_i       (dma_i),
    .kind_i      (kind_i),
    .hit_i       (hit),
    .at_entry_i  (at_entry),
    .at_second_i (at_second),
    .vd_shared_i (vd_shared_i),
    .vd_exec_i   (vd_exec_i),
    .prearm_i    (prearm_i),
    .armed_i     (armed),
    .arm_seg_i   (arm_seg_q),
    .viol_o      (viol),
    .arm_o       (arm),
    .arm_seg_o   (arm_seg_new),
    .open_o      (open_go),
    .close_o     (close_go)
  );

  seg_guard_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .viol_i    (viol),
    .arm_i     (arm),
    .arm_seg_i (arm_seg_new),
    .open_i    (open_go),
    .close_i   (close_go),
    .state_o   (state),
    .armed_o   (armed),
    .arm_seg_o (arm_seg_q),
    .rst_req_o (rst_req_o)
  );

  assign state_o = state;

  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_IDLE |=> !rst_req_o); // R1
  AST_ENABLE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != ST_IDLE |=> (state_o != ST_IDLE) || rst_req_o); // R2
  AST_DMA_KILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && dma_i && state_o != ST_IDLE && (hit[SEG_CODE] || hit[SEG_NVD]))
      |=> rst_req_o); // R10
  AST_OPEN_CODE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && state_o == ST_OPEN && hit[SEG_CODE] && kind_i == KIND_WRITE)
      |=> rst_req_o); // R7
  AST_EXIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_OPEN && $past(state_o) == ST_OPEN && !rst_req_o) |-> $stable(rst_req_o)); // R9
endmodule

// File: tb/sim_seg_guard.sv
module sim_seg_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, vld = 1'b0, dma = 1'b0, prearm = 1'b0;
  logic        vsh = 1'b0, vx = 1'b0;
  logic [1:0]  kind = 2'd1;
  logic [31:0] addr = '0;
  logic [31:0] cb = 32'h1000, cl = 32'h100;
  logic [31:0] nb = 32'h2000, nl = 32'h100;
  logic [31:0] vb = 32'h3000, vl = 32'h40;
  logic [1:0]  state_o;
  logic        rst_req_o;

  int checks = 0, bad = 0;
  bit done = 1'b0;
  string cur = "R1";

  always #10 clk = ~clk;

  seg_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .vld_i(vld), .dma_i(dma),
    .kind_i(kind), .addr_i(addr), .code_base_i(cb), .code_len_i(cl),
    .nvd_base_i(nb), .nvd_len_i(nl), .vd_base_i(vb), .vd_len_i(vl),
    .vd_shared_i(vsh), .vd_exec_i(vx), .prearm_i(prearm),
    .state_o(state_o), .rst_req_o(rst_req_o)
  );

  // behavioural reference
  int  m_state = 0;
  bit  m_req = 0, m_armed = 0;
  longint unsigned m_tgt = 0;

  function automatic bit inwin(longint unsigned a, longint unsigned b, longint unsigned l);
    return (l != 0) && (a >= b) && (a < b + l);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_req = 0; m_armed = 0;
    end else begin
      int ns;
      bit kill, f, w, ic, in_, iv, pv;
      longint unsigned a;
      ns = m_state; kill = 0; a = addr;
      f = (kind == 2'd0); w = (kind == 2'd2);
      ic = inwin(a, cb, cl); in_ = inwin(a, nb, nl); iv = inwin(a, vb, vl);
      pv = iv && !vsh;
      if (m_state == 0) begin
        if (enable) ns = 1;
      end else if (vld) begin
        if (dma) begin
          if (ic || in_ || pv) kill = 1;
        end else if (m_state == 1) begin
          if (m_armed) begin
            if (f && a == m_tgt) ns = 2; else kill = 1;
            m_armed = 0;
          end else if (f && cl != 0 && a == longint'(cb) + 4) begin
            m_armed = 1; m_tgt = longint'(cb) + 8;
          end else if (f && vl != 0 && vx && !vsh && a == longint'(vb) + 4) begin
            m_armed = 1; m_tgt = longint'(vb) + 8;
          end else if (ic || in_ || pv) kill = 1;
        end else begin
          if (ic && w) kill = 1;
          if (in_ && f) kill = 1;
          if (pv && f && !vx) kill = 1;
          if (f && !ic && !(iv && vx)) begin
            if (prearm) ns = 1; else kill = 1;
          end
        end
      end
      if (kill) begin ns = 0; m_armed = 0; end
      m_state = ns; m_req = kill;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (int'(state_o) != m_state || rst_req_o != m_req) begin
        bad++;
        $display("FAIL %s model compare: state=%0d req=%0d expected state=%0d req=%0d",
                 cur, state_o, rst_req_o, m_state, m_req);
      end
    end
  end

  task automatic chk(int st, bit rq, string tag);
    checks++;
    if (int'(state_o) != st || rst_req_o != rq) begin
      bad++;
      $display("FAIL %s: state=%0d req=%0d expected state=%0d req=%0d",
               tag, state_o, rst_req_o, st, rq);
    end
  endtask

  task automatic xfer(logic [1:0] k, logic [31:0] a, bit d);
    @(negedge clk);
    vld = 1'b1; kind = k; addr = a; dma = d;
    @(negedge clk);
    vld = 1'b0; dma = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic open_code();
    xfer(2'd0, cb + 4, 0);
    xfer(2'd0, cb + 8, 0);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
    end
  end

  initial begin
    idle(2);
    chk(0, 0, "R1");
    rst_n = 1'b1;
    idle(1);
    chk(0, 0, "R1");
    cur = "R1";
    xfer(2'd0, cb + 32'h20, 0); chk(0, 0, "R1");
    xfer(2'd2, nb + 32'h10, 0); chk(0, 0, "R1");
    xfer(2'd1, cb, 1);          chk(0, 0, "R1");

    cur = "R2";
    enable = 1'b1; idle(1); chk(1, 0, "R2");
    enable = 1'b0; idle(3); chk(1, 0, "R2");
    enable = 1'b1;

    cur = "R3";
    xfer(2'd1, cb - 1, 0);       chk(1, 0, "R3");
    xfer(2'd1, cb + cl, 0);      chk(1, 0, "R3");
    xfer(2'd1, cb + cl - 1, 0);  chk(0, 1, "R3");
    idle(1);                     chk(1, 0, "R11");
    nl = 32'h0;
    xfer(2'd2, nb, 0);           chk(1, 0, "R3");
    nl = 32'h100;

    cur = "R4";
    xfer(2'd2, nb + 8, 0);  chk(0, 1, "R4"); idle(1);
    xfer(2'd1, vb + 8, 0);  chk(0, 1, "R4"); idle(1);
    xfer(2'd0, cb, 0);      chk(0, 1, "R4"); idle(1);
    xfer(2'd3, cb + 16, 0); chk(0, 1, "R4"); idle(1);

    cur = "R5";
    xfer(2'd0, cb + 4, 0);  chk(1, 0, "R5");
    idle(3);
    xfer(2'd0, cb + 8, 0);  chk(2, 0, "R5");
    prearm = 1'b1;
    xfer(2'd0, 32'h500, 0); chk(1, 0, "R9");
    xfer(2'd0, cb + 4, 0);
    xfer(2'd1, cb + 8, 0);  chk(0, 1, "R5"); idle(1);
    xfer(2'd0, cb + 4, 0);
    xfer(2'd0, cb + 4, 0);  chk(0, 1, "R5"); idle(1);
    xfer(2'd0, cb + 8, 0);  chk(0, 1, "R5"); idle(1);

    cur = "R7";
    open_code();
    xfer(2'd1, cb + 32'h50, 0); chk(2, 0, "R7");
    xfer(2'd0, cb + 32'h60, 0); chk(2, 0, "R7");
    xfer(2'd1, nb + 4, 0);      chk(2, 0, "R7");
    xfer(2'd2, nb + 4, 0);      chk(2, 0, "R7");
    xfer(2'd2, cb + 32'h60, 0); chk(0, 1, "R7"); idle(1);
    open_code();
    xfer(2'd0, nb + 4, 0);      chk(0, 1, "R7"); idle(1);

    cur = "R8";
    open_code();
    xfer(2'd2, vb + 16, 0);     chk(2, 0, "R8");
    xfer(2'd0, vb + 16, 0);     chk(0, 1, "R8"); idle(1);

    cur = "R6";
    vx = 1'b1;
    xfer(2'd0, vb + 4, 0);      chk(1, 0, "R6");
    xfer(2'd0, vb + 8, 0);      chk(2, 0, "R6");
    xfer(2'd0, vb + 32, 0);     chk(2, 0, "R8");
    xfer(2'd0, cb + 32, 0);     chk(2, 0, "R9");
    prearm = 1'b0;
    xfer(2'd0, 32'h500, 0);     chk(0, 1, "R9"); idle(1);
    prearm = 1'b1;
    vx = 1'b0;
    xfer(2'd0, vb + 4, 0);      chk(0, 1, "R6"); idle(1);
    vsh = 1'b1; vx = 1'b1;
    xfer(2'd0, vb + 4, 0);      chk(1, 0, "R6");
    xfer(2'd0, vb + 8, 0);      chk(1, 0, "R6");
    vx = 1'b0;
    cur = "R8";
    xfer(2'd2, vb + 12, 0);     chk(1, 0, "R8");
    xfer(2'd0, vb + 12, 0);     chk(1, 0, "R8");
    xfer(2'd1, vb + 12, 1);     chk(1, 0, "R8");
    vsh = 1'b0;

    cur = "R10";
    xfer(2'd1, cb + 16, 1);     chk(0, 1, "R10"); idle(1);
    xfer(2'd1, 32'h500, 1);     chk(1, 0, "R10");
    open_code();
    xfer(2'd0, 32'h500, 1);     chk(2, 0, "R10");
    xfer(2'd2, vb + 4, 1);      chk(0, 1, "R10");
    idle(1);                    chk(1, 0, "R11");

    cur = "R11";
    for (int ph = 0; ph < 4; ph++) begin
      vsh = ph[0]; vx = ph[1];
      for (int i = 0; i < 300; i++) begin
        int pick;
        logic [31:0] a;
        pick = int'($urandom_range(0, 10));
        case (pick)
          0: a = cb + 4;  1: a = cb + 8;  2: a = cb + 32'h10;
          3: a = nb + 8;  4: a = vb + 4;  5: a = vb + 8;
          6: a = vb + 32'h10; 7: a = 32'h500; 8: a = cb - 1;
          9: a = cb + cl; default: a = nb + nl - 1;
        endcase
        @(negedge clk);
        prearm = $urandom_range(0, 1) != 0;
        vld    = $urandom_range(0, 3) != 0;
        dma    = $urandom_range(0, 7) == 0;
        kind   = 2'($urandom_range(0, 3));
        addr   = a;
      end
      @(negedge clk);
      vld = 1'b0;
      // leave any pending entry so attributes change only in a quiet CLOSE
      xfer(2'd1, 32'h500, 1);
      xfer(2'd2, cb, 0);
      idle(2);
    end

    done = 1'b1;
    summary();
  end
endmodule